// File: doc/BRIEF.md
# Shared-Memory Exclusive Reservation Tracker

This block keeps the reservation state that store-exclusive operations need when several requesters share one memory. Each requester has an open-or-reserved flag, a full-width reserved address and a small counter of successful store-exclusives. One access that has already been arbitrated arrives per cycle, carrying a requester number, an address and an access kind. For a store-exclusive the block answers pass or fail in the same cycle. The reservation state changes at the next clock edge.

Plain stores are treated strictly: they drop every reservation, whatever their address. A store-exclusive that passes also drops the reservations of other requesters whose reserved address falls in the same coarse granule. The success counter makes one otherwise good store-exclusive fail after a programmed number of passes. This models the spurious loss of a reservation, so software retry loops are exercised.

Top module: `xmon_top`

## Requirements
- R1: After reset every requester is open with a zero reserved address and a zero success count, so a store-exclusive to address 0 fails.
- R2: A load-exclusive (access kind 2) reserves the full address for the requester that issues it, replacing any earlier reservation of that requester.
- R3: A store-exclusive (kind 3) drives `stex_pass` high in the same cycle only if its requester is reserved and the address equals the reserved address exactly in every bit. Otherwise `stex_pass` is low.
- R4: Every store-exclusive, whether it passes or fails, returns its requester to open.
- R5: A plain store (kind 1) from any requester, including a reservation owner, returns every requester to open, whatever the address.
- R6: When a store-exclusive passes, each other reserved requester is returned to open if its reserved address matches the store address with the low `GRAN_LSB` bits ignored. Requesters outside that granule keep their reservation.
- R7: A requester whose success count has reached `FAIL_MAX` fails its next otherwise-passing store-exclusive, and its count goes back to zero. With the default `FAIL_MAX` of 7, the eighth good attempt fails and the ninth passes. A forced failure drops no other requester's reservation.
- R8: Plain loads (kind 0) and cycles with `acc_valid` low change no state. `stex_pass` stays low on any cycle that does not present a valid store-exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_id | input | $clog2(N_REQ) | Requester number |
| acc_kind | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| acc_addr | input | ADDR_W | Byte address of the access |
| stex_pass | output | 1 | Same-cycle store-exclusive verdict, 1 = pass |

## Verification
The verdict is combinational: it is due in the cycle the store-exclusive is presented, from the state left by earlier accesses. Every state change an access makes becomes visible only from the following cycle. The bench drives each access on the falling edge and samples `stex_pass` one nanosecond later, before the rising edge commits the access. A later access then observes the new state. Hidden state such as reservations and counters is checked through later store-exclusive verdicts.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_LDEX  = 2'd2,
    ACC_STEX  = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/xmon_decode.sv
module xmon_decode
  import xmon_pkg::*;
#(
  parameter int N_REQ = 4,
  localparam int IDW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic           acc_valid,
  input  logic [IDW-1:0] acc_id,
  input  logic [1:0]     acc_kind,
  output logic [N_REQ-1:0] ldex_vec,
  output logic [N_REQ-1:0] stex_vec,
  output logic           store_any
);
  assign store_any = acc_valid && (acc_kind == ACC_STORE);

  for (genvar i = 0; i < N_REQ; i++) begin : g_sel
    logic mine;
    assign mine        = acc_valid && (acc_id == IDW'(i));
    assign ldex_vec[i] = mine && (acc_kind == ACC_LDEX);
    assign stex_vec[i] = mine && (acc_kind == ACC_STEX);
  end
endmodule

// File: rtl/xmon_slot.sv
module xmon_slot #(
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  parameter int FAIL_MAX = 7,
  localparam int CNT_W   = $clog2(FAIL_MAX + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ldex,
  input  logic              ev_stex,
  input  logic              ev_store,
  input  logic              ev_peer_win,
  input  logic [ADDR_W-1:0] addr,
  output logic              excl_o,
  output logic              pass_o,
  output logic              forced_o
);
  logic              excl_q;
  logic [ADDR_W-1:0] tag_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic same_granule(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return (a >> GRAN_LSB) == (b >> GRAN_LSB);
  endfunction

  function automatic logic quota_spent(input logic [CNT_W-1:0] c);
    return c >= CNT_W'(FAIL_MAX);
  endfunction

  logic exact_hit, peer_clear, drop;
  assign exact_hit  = excl_q && (addr == tag_q);
  assign pass_o     = ev_stex && exact_hit && !quota_spent(cnt_q);
  assign forced_o   = ev_stex && exact_hit && quota_spent(cnt_q);
  assign peer_clear = ev_peer_win && excl_q && same_granule(addr, tag_q);
  assign drop       = ev_store || ev_stex || peer_clear;
  assign excl_o     = excl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q <= 1'b0;
      tag_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (drop) begin
        excl_q <= 1'b0;
        tag_q  <= '0;
      end else if (ev_ldex) begin
        excl_q <= 1'b1;
        tag_q  <= addr;
      end
      if (ev_stex && exact_hit)
        cnt_q <= quota_spent(cnt_q) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: a load-exclusive leaves the slot reserved on its address
  a_r2_ldex_reserves: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ldex && !ev_peer_win) |=> (excl_q && tag_q == $past(addr)));
  // R4: any store-exclusive of this requester opens it
  a_r4_stex_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stex |=> !excl_q);
  // R5: a plain store opens every slot
  a_r5_store_opens: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (!excl_q && tag_q == '0));
  // R7: counter never passes its limit and restarts after a forced failure
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FAIL_MAX));
  a_r7_forced_restart: assert property (@(posedge clk) disable iff (!rst_n)
    forced_o |=> (cnt_q == '0));
  // R8: no event, no state change
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ldex || ev_stex || ev_store || ev_peer_win) |=>
      ($stable(excl_q) && $stable(tag_q) && $stable(cnt_q)));
endmodule

// File: rtl/xmon_top.sv
module xmon_top #(
  parameter int N_REQ    = 4,
  parameter int ADDR_W   = 32,
  parameter int GRAN_LSB = 4,
  parameter int FAIL_MAX = 7,
  localparam int IDW     = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [IDW-1:0]    acc_id,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              stex_pass
);
  logic [N_REQ-1:0] ldex_vec, stex_vec, pass_vec, forced_vec, excl_vec;
  logic             store_any, win_any;

  xmon_decode #(.N_REQ(N_REQ)) u_dec (
    .acc_valid (acc_valid),
    .acc_id    (acc_id),
    .acc_kind  (acc_kind),
    .ldex_vec  (ldex_vec),
    .stex_vec  (stex_vec),
    .store_any (store_any)
  );

  assign win_any   = |pass_vec;
  assign stex_pass = win_any;

  for (genvar i = 0; i < N_REQ; i++) begin : g_slot
    xmon_slot #(
      .ADDR_W  (ADDR_W),
      .GRAN_LSB(GRAN_LSB),
      .FAIL_MAX(FAIL_MAX)
    ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_ldex    (ldex_vec[i]),
      .ev_stex    (stex_vec[i]),
      .ev_store   (store_any),
      .ev_peer_win(win_any && !pass_vec[i]),
      .addr       (acc_addr),
      .excl_o     (excl_vec[i]),
      .pass_o     (pass_vec[i]),
      .forced_o   (forced_vec[i])
    );
  end

  // R3: at most one requester can win, and only on a store-exclusive
  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pass_vec | forced_vec));
  a_r8_pass_needs_stex: assert property (@(posedge clk) disable iff (!rst_n)
    stex_pass |-> (acc_valid && acc_kind == 2'd3));
  // R5: after a plain store nobody holds a reservation
  a_r5_all_open: assert property (@(posedge clk) disable iff (!rst_n)
    store_any |=> (excl_vec == '0));
endmodule

// File: tb/sim_xmon_top.sv
`timescale 1ns/1ps
module sim_xmon_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_id = '0;
  logic [1:0]  acc_kind = '0;
  logic [31:0] acc_addr = '0;
  logic        stex_pass;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xmon_top u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_id(acc_id),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .stex_pass(stex_pass)
  );

  // {exp nibble, kind[1:0] id[1:0], addr}: kinds 0 LD 1 ST 2 LDEX 3 STEX
  localparam logic [39:0] VEC [24] = '{
    40'h0C_00000100, // R3 id0 never reserved: fail
    40'h08_00000100, // R2 id0 reserve 0x100
    40'h00_00000100, // R8 plain load keeps it
    40'h1C_00000100, // R3 pass
    40'h0C_00000100, // R4 open after pass: fail
    40'h09_00000200, // id1 reserve 0x200
    40'h0A_00000204, // id2 reserve same granule
    40'h0B_00000300, // id3 reserve other granule
    40'h1D_00000200, // R6 id1 pass, clears id2
    40'h0E_00000204, // R6 id2 fails
    40'h1F_00000300, // R6 id3 kept: pass
    40'h08_00000400, // id0 reserve
    40'h05_00000999, // R5 store by id1 elsewhere
    40'h0C_00000400, // R5 id0 fails
    40'h0A_00000500, // id2 reserve
    40'h0E_00000504, // R3 inexact in granule: fail
    40'h0E_00000500, // R4 cleared by failing attempt
    40'h0B_00000600, // id3 reserve
    40'h07_00000600, // R5 own store
    40'h0F_00000600, // R5 fail
    40'h08_00000700, // id0 reserve
    40'h09_00000710, // id1 reserve other granule
    40'h1C_00000700, // R6 pass
    40'h1D_00000710  // R6 id1 kept: pass
  };

  task automatic acc(input int id, input int kind, input logic [31:0] a,
                     input logic exp, input string req);
    @(negedge clk);
    acc_valid = 1'b1; acc_id = 2'(id); acc_kind = 2'(kind); acc_addr = a;
    #1;
    if (kind == 3) begin
      checks++;
      if (stex_pass !== exp) begin
        errors++;
        $display("FAIL %s: id%0d addr %h stex_pass=%b expected %b", req, id, a, stex_pass, exp);
      end
    end
  endtask

  task automatic idle_check(input string req);
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd3;
    #1;
    checks++;
    if (stex_pass !== 1'b0) begin
      errors++;
      $display("FAIL %s: stex_pass=%b expected 0 while idle", req, stex_pass);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; acc_valid = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    acc(0, 3, 32'h0, 1'b0, "R1 store-exclusive after reset");
    for (int k = 0; k < 24; k++)
      acc(int'(VEC[k][33:32]), int'(VEC[k][35:34]), VEC[k][31:0], VEC[k][36],
          $sformatf("table step %0d", k));

    // R7: seven passes, the eighth fails, others untouched, then pass again
    do_reset();
    for (int k = 0; k < 7; k++) begin
      acc(0, 2, 32'h800, 1'b0, "R7");
      acc(0, 3, 32'h800, 1'b1, "R7 pass within quota");
    end
    acc(1, 2, 32'h804, 1'b0, "R7");
    acc(0, 2, 32'h800, 1'b0, "R7");
    acc(0, 3, 32'h800, 1'b0, "R7 forced failure");
    acc(1, 3, 32'h804, 1'b1, "R7 forced failure keeps peer");
    acc(0, 2, 32'h800, 1'b0, "R7");
    acc(0, 3, 32'h800, 1'b1, "R7 pass after count restart");

    // R8: idle cycles showing store kind change nothing
    acc(2, 2, 32'h900, 1'b0, "R8");
    @(negedge clk); acc_valid = 1'b0; acc_kind = 2'd1;
    idle_check("R8 idle verdict");
    acc(2, 3, 32'h900, 1'b1, "R8 reservation survived idle store");

    // R2: newer reservation replaces older one
    acc(3, 2, 32'hA00, 1'b0, "R2");
    acc(3, 2, 32'hB00, 1'b0, "R2");
    acc(3, 3, 32'hA00, 1'b0, "R2 old address dropped");
    acc(3, 2, 32'hA00, 1'b0, "R2");
    acc(3, 2, 32'hB00, 1'b0, "R2");
    acc(3, 3, 32'hB00, 1'b1, "R2 new address held");

    // R1: reset clears a live reservation
    acc(1, 2, 32'h0, 1'b0, "R1");
    do_reset();
    acc(1, 3, 32'h0, 1'b0, "R1 reservation lost in reset");

    @(negedge clk); acc_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule